// File: doc/BRIEF.md
# Dual-Source Sixteen-Bit Step Counter

This block keeps a sixteen-bit binary count that moves up by one each time an increment event is accepted. Events come from one of two places, and a mode switch picks which. In automatic mode a divider produces one event for every `TICK_PERIOD` clock cycles in which the count-enable input is high. At the default setting this is once per second on a 100 MHz clock. In manual mode, each debounced press of a push button produces one event.

All logic runs on the one system clock. Each event source makes a single-cycle enable pulse, and no derived clock is used. The raw button passes through a two-stage synchronizer. It then goes through a stability filter that accepts a new level only after that level has held for `DEBOUNCE_CYCLES` cycles. Only an accepted rising level counts as a press. The divider and the debouncer keep running whatever the mode is, and the mode switch only chooses which pulse reaches the counter.

Top module: `dual_mode_counter`

## Requirements
- R1: Reset clears `count` to 0, and `count` changes only by exactly +1 on a clock edge where an accepted event from the selected source occurs.
- R2: The count wraps from 16'hFFFF to 16'h0000 on the next accepted event.
- R3: With `mode_auto` = 1, `count` steps on every `TICK_PERIOD`-th rising edge at which `cnt_en` is high, counted from reset.
- R4: With `mode_auto` = 0, `btn_raw` going from 0 to 1 and staying at 1 makes `count` step at the (`DEBOUNCE_CYCLES`+2)-th rising edge after the change, and not earlier.
- R5: A high pulse on `btn_raw` shorter than `DEBOUNCE_CYCLES` cycles produces no step. A pulse of exactly `DEBOUNCE_CYCLES` cycles produces one step.
- R6: A button held down for any length of time produces exactly one step, and its release produces none.
- R7: In automatic mode button presses have no effect on `count`. In manual mode divider ticks have no effect on `count`.
- R8: Toggling `mode_auto` never produces a step by itself. This holds even while the button is held down or after a press was accepted in the other mode.
- R9: Synchronous reset also clears the divider progress and the debouncer state. After reset the first tick needs a full period, and a button held through reset is counted once, at the (`DEBOUNCE_CYCLES`+2)-th edge after reset is released.
- R10: While `cnt_en` is low the divider holds its progress, and enabled cycles before and after such a gap add up toward the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high; clears all state |
| mode_auto | input | 1 | 1 selects the divider tick, 0 selects the debounced button |
| btn_raw | input | 1 | Asynchronous push-button level, active high |
| cnt_en | input | 1 | Enable for the tick divider; one divider step per high cycle |
| count | output | 16 | Current count value |

## Verification
A reset takes effect at the first edge. A tick-driven step appears at the edge where the `TICK_PERIOD`-th enabled cycle completes. A press appears `DEBOUNCE_CYCLES`+2 edges after the raw level changes: two synchronizer edges, then the stability window. The bench drives every input just after a falling edge and waits a counted number of falling edges before it samples `count`. Each directed check therefore falls one edge before and one edge at the due cycle. The random phase compares against a bench reference model that steps on the same rising edges.

// File: rtl/dual_mode_counter.sv
module dual_mode_counter #(
  parameter int COUNT_W         = 16,
  parameter int TICK_PERIOD     = 100_000_000,
  parameter int DEBOUNCE_CYCLES = 1_000_000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode_auto,
  input  logic               btn_raw,
  input  logic               cnt_en,
  output logic [COUNT_W-1:0] count
);

  localparam int DIV_W = (TICK_PERIOD > 1) ? $clog2(TICK_PERIOD) : 1;
  localparam int DEB_W = (DEBOUNCE_CYCLES > 1) ? $clog2(DEBOUNCE_CYCLES) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_PERIOD - 1);
  localparam logic [DEB_W-1:0] DEB_LAST = DEB_W'(DEBOUNCE_CYCLES - 1);

  logic [DIV_W-1:0] div_cnt;
  logic             tick;

  assign tick = cnt_en && (div_cnt == DIV_LAST);

  always_ff @(posedge clk) begin
    if (rst)         div_cnt <= '0;
    else if (cnt_en) div_cnt <= tick ? '0 : div_cnt + 1'b1;
  end

  logic             btn_s1, btn_s2, btn_lvl;
  logic [DEB_W-1:0] deb_cnt;
  logic             deb_diff, deb_full, press;

  assign deb_diff = btn_s2 != btn_lvl;
  assign deb_full = deb_cnt == DEB_LAST;
  assign press    = deb_diff && deb_full && btn_s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      btn_s1  <= 1'b0;
      btn_s2  <= 1'b0;
      btn_lvl <= 1'b0;
      deb_cnt <= '0;
    end else begin
      btn_s1 <= btn_raw;
      btn_s2 <= btn_s1;
      if (!deb_diff) begin
        deb_cnt <= '0;
      end else if (deb_full) begin
        btn_lvl <= btn_s2;
        deb_cnt <= '0;
      end else begin
        deb_cnt <= deb_cnt + 1'b1;
      end
    end
  end

  logic step;
  assign step = mode_auto ? tick : press;

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (step) count <= count + 1'b1;
  end

endmodule

// File: rtl/dual_mode_counter_checker.sv
module dual_mode_counter_checker #(
  parameter int COUNT_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               mode_auto,
  input logic               tick,
  input logic               press,
  input logic [COUNT_W-1:0] count
);

  assert_step_one_R1: assert property (@(posedge clk) disable iff (rst)
    (count != $past(count)) |-> (count == COUNT_W'($past(count) + 1'b1)));

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (count == '0));

  assert_auto_ignores_button_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_auto && !tick) |=> (count == $past(count)));

  assert_manual_ignores_tick_R7: assert property (@(posedge clk) disable iff (rst)
    (!mode_auto && !press) |=> (count == $past(count)));

  assert_press_single_R6: assert property (@(posedge clk) disable iff (rst)
    press |=> !press);

  assert_tick_spaced_R3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

bind dual_mode_counter dual_mode_counter_checker #(.COUNT_W(COUNT_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .mode_auto(mode_auto),
  .tick     (tick),
  .press    (press),
  .count    (count)
);

// File: tb/dual_mode_counter_tb_top.sv
module dual_mode_counter_tb_top;

  localparam int P   = 2;
  localparam int DEB = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_auto = 1'b0;
  logic        btn_raw = 1'b0;
  logic        cnt_en = 1'b0;
  logic [15:0] count;

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  dual_mode_counter #(.COUNT_W(16), .TICK_PERIOD(P), .DEBOUNCE_CYCLES(DEB)) dut_i (
    .clk(clk), .rst(rst), .mode_auto(mode_auto),
    .btn_raw(btn_raw), .cnt_en(cnt_en), .count(count)
  );

  // reference model built from the requirements
  logic        m_d1, m_d2, m_level;
  int          m_run, m_div;
  logic [15:0] m_count;

  function automatic logic [15:0] inc16(input logic [15:0] v);
    return v + 16'd1;
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      m_d1 <= 0; m_d2 <= 0; m_level <= 0; m_run <= 0; m_div <= 0; m_count <= 0;
    end else begin
      m_d1 <= btn_raw;
      m_d2 <= m_d1;
      if (m_d2 == m_level) m_run <= 0;
      else if (m_run + 1 >= DEB) begin
        m_level <= m_d2;
        m_run   <= 0;
        if (m_d2 && !mode_auto) m_count <= inc16(m_count);
      end else m_run <= m_run + 1;
      if (cnt_en) begin
        if (m_div + 1 == P) begin
          m_div <= 0;
          if (mode_auto) m_count <= inc16(m_count);
        end else m_div <= m_div + 1;
      end
    end
  end

  task automatic summary_and_exit();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles >= 190000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected below 190000", cycles);
      summary_and_exit();
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] exp);
    n_run++;
    if (count !== exp) begin
      n_fail++;
      $display("FAIL %s: count actual %h expected %h", req, count, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(3);
    rst = 1'b0;
  endtask

  initial begin
    process::self().srandom(32'h5eed_1234);
    @(negedge clk);
    do_reset();
    check("R1 reset", 16'h0000);

    // R3: first tick on the P-th enabled edge
    mode_auto = 1; cnt_en = 1;
    cyc(1); check("R3 before tick", 16'h0000);
    cyc(1); check("R3 tick", 16'h0001);

    // R10: progress held across an enable gap
    cyc(1); cnt_en = 0;
    cyc(5); check("R10 gap hold", 16'h0001);
    cnt_en = 1;
    cyc(1); check("R10 resume", 16'h0002);
    cnt_en = 0;

    // R4: manual press latency
    mode_auto = 0; btn_raw = 1;
    cyc(DEB + 1); check("R4 early", 16'h0002);
    cyc(1);       check("R4 due", 16'h0003);

    // R6: held press and release
    cyc(20); check("R6 held", 16'h0003);
    btn_raw = 0;
    cyc(10); check("R6 release", 16'h0003);

    // R5: short glitch vs exact window
    btn_raw = 1; cyc(DEB - 1); btn_raw = 0;
    cyc(10); check("R5 short glitch", 16'h0003);
    btn_raw = 1; cyc(DEB); btn_raw = 0;
    cyc(10); check("R5 exact window", 16'h0004);

    // R7: button ignored in automatic mode, ticks ignored in manual
    mode_auto = 1; cnt_en = 0; btn_raw = 1;
    cyc(10); btn_raw = 0; cyc(10);
    check("R7 button in auto", 16'h0004);
    mode_auto = 0; cnt_en = 1;
    cyc(20); check("R7 tick in manual", 16'h0004);
    cnt_en = 0;

    // R8: mode toggling with a held, accepted press
    btn_raw = 1; cyc(10); check("R8 setup press", 16'h0005);
    for (int i = 0; i < 12; i++) begin
      mode_auto = ~mode_auto; cyc(1);
    end
    mode_auto = 1; cyc(3); mode_auto = 0; cyc(3);
    check("R8 toggles", 16'h0005);
    btn_raw = 0; cyc(10);
    check("R8 after release", 16'h0005);

    // R9: button held through reset
    btn_raw = 1;
    do_reset();
    check("R9 reset clears", 16'h0000);
    cyc(DEB + 1); check("R9 held early", 16'h0000);
    cyc(1);       check("R9 held due", 16'h0001);
    btn_raw = 0; cyc(10);

    // R9: divider progress cleared
    mode_auto = 1; cnt_en = 1; cyc(1); cnt_en = 0;
    do_reset();
    cnt_en = 1;
    cyc(1); check("R9 divider cleared", 16'h0000);
    cyc(1); check("R9 full period", 16'h0001);

    // random phase against the reference model
    cnt_en = 0; mode_auto = 0; btn_raw = 0;
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      if (i % 97 == 0) mode_auto = $urandom_range(0, 1);
      cnt_en = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 5) == 0) btn_raw = ~btn_raw;
      cyc(1);
      if (i % 25 == 24) check("R1 R7 random", m_count);
    end

    // R2: wrap
    btn_raw = 0;
    do_reset();
    mode_auto = 1; cnt_en = 1;
    cyc(P * 65535); check("R2 at max", 16'hFFFF);
    cyc(P);         check("R2 wrap", 16'h0000);

    summary_and_exit();
  end

endmodule